// File: doc/BRIEF.md
# Eight-Line Programmable Priority Interrupt Controller

This block collects up to eight interrupt request lines and tells a processor when one of them deserves service. Each request line is edge captured, can be masked, and moves into an in-service set when the processor acknowledges it. Priority is circular. A three-bit rotation base names the line that currently ranks highest. The end-of-interrupt commands, automatic end-of-interrupt and explicit commands can all move that base.

Software reaches the block through a byte-wide port with a single address bit. On address 0, writes are decoded as an initialisation start, a control word or a command word. Address 1 carries the remaining initialisation words and, in normal mode, the mask. Reads return the mask, the request set or the in-service set. A poll request turns the next read into an acknowledge-free query for the winning line. A separate acknowledge strobe produces an 8-bit vector, formed from the programmed vector base and the selected line number.

Top module: `irqc_top`

## Requirements
- R1: After reset `int_out` is low, the request, mask and in-service sets are zero, the rotation base and vector base are zero, all mode flags are clear and the block is in normal mode.
- R2: A 0-to-1 transition of `irq_in[i]` sets request bit i one clock later. A line that stays high does not set the bit again after it has been cleared.
- R3: Line (base+k) mod 8 has rank k, and rank 0 is the highest. `int_out` is high one cycle after any state change exactly when the best rank in (request AND NOT mask) is better than the best rank in the in-service set. Under special mask, the in-service set is first ANDed with NOT mask. Under fully-nested mode, in-service bit 2 is ignored.
- R4: A write to address 0 with bit 4 set clears request, mask, in-service, rotation base, vector base and all mode flags, and forces `int_out` low on the next cycle. It records bit 0 as "fourth word wanted" and bit 1 as "single", and then waits for the base word.
- R5: The next address-1 write loads the vector base from bits 7:3. If the block is not single, one cascade word follows. A fourth word follows if it was wanted; in that word, bit 4 sets fully-nested mode and bit 1 sets automatic end-of-interrupt. After the last expected word the block returns to normal mode.
- R6: In normal mode an address-1 write loads the mask. A read of address 1 returns the mask. A read of address 0 returns the in-service set if read-select is 1, and otherwise the request set. `rd_data` is valid one cycle after `rd_en`.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a control word. Bit 2 sets a pending poll. If bit 1 is 1, bit 0 becomes read-select. If bit 6 is 1, bit 5 becomes the special-mask flag.
- R8: An address-0 write with bits 4 and 3 both 0 is a command, selected by bits 7:5. Code 0 clears rotate-on-auto and code 4 sets it. Code 1 clears the best-ranked in-service bit, and code 5 also sets the base to that line+1; both do nothing if the in-service set is empty. Code 3 clears in-service bit [2:0]. Code 6 sets the base to [2:0]+1. Code 7 clears in-service bit [2:0] and sets the base to [2:0]+1. Code 2 does nothing.
- R9: On `ack` with a qualifying request (as in R3), the next `vector` is {vector base, line}. The request bit is cleared, and without automatic end-of-interrupt the in-service bit is set.
- R10: With automatic end-of-interrupt, an acknowledge sets no in-service bit. If rotate-on-auto is also set, the base becomes line+1 mod 8.
- R11: An `ack` with no qualifying request returns {vector base, 7} and changes no state.
- R12: With a poll pending, the next read returns the winning line number (upper bits zero) and clears that line's request and in-service bits. If nothing qualifies it returns 7. The poll then clears itself.
- R13: When strobes coincide, a write takes precedence over a read and a read over an acknowledge. The strobes that lose have no effect, so `rd_data` and `vector` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 8 | Interrupt request lines, edge captured |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register port address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ack | input | 1 | Interrupt acknowledge strobe |
| vector | output | 8 | Registered vector from the last acknowledge |
| int_out | output | 1 | Registered interrupt request to the processor |

## Verification
The bound checker watches several rules on every cycle:
- an initialisation start forces the output low;
- a normal-mode mask write lands;
- the vector's upper field always equals the programmed base;
- automatic end-of-interrupt never touches the in-service set;
- a pending poll clears after a read;
- a losing read leaves `rd_data` unchanged.

The rotating ranking itself can only be shown by the bench. So can the end-of-interrupt variants that move the base, the interplay of special mask and fully-nested mode, spurious acknowledges and the initialisation sequences. The bench compares every read, vector and output level against a reference model of the register state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LINES  = 8;
  localparam int IDX_W  = $clog2(LINES);
  localparam int DATA_W = 8;
  localparam int VB_W   = DATA_W - IDX_W;

  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_BASE   = 2'd1,
    ST_CASC   = 2'd2,
    ST_FOURTH = 2'd3
  } init_st_e;
endpackage

// File: rtl/irqc_edge_cap.sv
module irqc_edge_cap #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) last_q <= '0;
    else     last_q <= lines_in;
  end

  assign rise = lines_in & ~last_q;
endmodule

// File: rtl/irqc_rank.sv
// Rank of the best set bit of vec, counted circularly from line base.
// Returns N when vec is empty.
module irqc_rank #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] vec,
  input  logic [W-1:0] base,
  output logic [W:0]   rank
);
  always_comb begin
    rank = (W+1)'(N);
    for (int k = N - 1; k >= 0; k--) begin
      if (vec[W'(base + W'(k))]) rank = (W+1)'(k);
    end
  end
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [LINES-1:0]  irq_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ack,
  output logic [DATA_W-1:0] vector,
  output logic              int_out
);
  logic [LINES-1:0]  irr_q, imr_q, isr_q;
  logic [LINES-1:0]  irr_d, imr_d, isr_d;
  logic [IDX_W-1:0]  base_q, base_d;
  logic [VB_W-1:0]   vbase_q, vbase_d;
  logic              rdsel_q, rdsel_d, poll_q, poll_d, smm_q, smm_d;
  logic              aeoi_q, aeoi_d, rot_q, rot_d, fnm_q, fnm_d;
  logic              need4_q, need4_d, single_q, single_d;
  init_st_e          st_q, st_d;
  logic [DATA_W-1:0] rd_q, rd_d, vec_q, vec_d;
  logic              int_q, int_d;
  logic              in_normal;

  logic [LINES-1:0]  rise;
  logic [LINES-1:0]  cur_vec;
  logic [IDX_W:0]    pend_rank, cur_rank, eoi_rank;
  logic [IDX_W-1:0]  pend_line, eoi_line;
  logic              fire;

  irqc_edge_cap #(.N(LINES)) u_edge (
    .clk(clk), .rst(rst), .lines_in(irq_in), .rise(rise)
  );

  // Shielded in-service view used to decide whether a request may preempt.
  always_comb begin
    cur_vec = isr_q;
    if (smm_q) cur_vec = cur_vec & ~imr_q;
    if (fnm_q) cur_vec[2] = 1'b0;
  end

  irqc_rank #(.N(LINES)) u_pend (.vec(irr_q & ~imr_q), .base(base_q), .rank(pend_rank));
  irqc_rank #(.N(LINES)) u_cur  (.vec(cur_vec),        .base(base_q), .rank(cur_rank));
  irqc_rank #(.N(LINES)) u_eoi  (.vec(isr_q),          .base(base_q), .rank(eoi_rank));

  assign pend_line = base_q + pend_rank[IDX_W-1:0];
  assign eoi_line  = base_q + eoi_rank[IDX_W-1:0];
  assign fire      = (pend_rank < cur_rank);
  assign in_normal = (st_q == ST_NORMAL);

  always_comb begin
    irr_d    = irr_q | rise;
    imr_d    = imr_q;
    isr_d    = isr_q;
    base_d   = base_q;
    vbase_d  = vbase_q;
    rdsel_d  = rdsel_q;
    poll_d   = poll_q;
    smm_d    = smm_q;
    aeoi_d   = aeoi_q;
    rot_d    = rot_q;
    fnm_d    = fnm_q;
    need4_d  = need4_q;
    single_d = single_q;
    st_d     = st_q;
    rd_d     = rd_q;
    vec_d    = vec_q;
    int_d    = fire;

    if (wr_en) begin
      if (!addr) begin
        if (wr_data[4]) begin
          irr_d    = '0;
          imr_d    = '0;
          isr_d    = '0;
          base_d   = '0;
          vbase_d  = '0;
          rdsel_d  = 1'b0;
          poll_d   = 1'b0;
          smm_d    = 1'b0;
          aeoi_d   = 1'b0;
          rot_d    = 1'b0;
          fnm_d    = 1'b0;
          need4_d  = wr_data[0];
          single_d = wr_data[1];
          st_d     = ST_BASE;
          int_d    = 1'b0;
        end else if (wr_data[3]) begin
          if (wr_data[2]) poll_d  = 1'b1;
          if (wr_data[1]) rdsel_d = wr_data[0];
          if (wr_data[6]) smm_d   = wr_data[5];
        end else begin
          case (wr_data[7:5])
            3'd0: rot_d = 1'b0;
            3'd4: rot_d = 1'b1;
            3'd1, 3'd5: begin
              if (!eoi_rank[IDX_W]) begin
                isr_d[eoi_line] = 1'b0;
                if (wr_data[7]) base_d = eoi_line + IDX_W'(1);
              end
            end
            3'd3: isr_d[wr_data[IDX_W-1:0]] = 1'b0;
            3'd6: base_d = wr_data[IDX_W-1:0] + IDX_W'(1);
            3'd7: begin
              isr_d[wr_data[IDX_W-1:0]] = 1'b0;
              base_d = wr_data[IDX_W-1:0] + IDX_W'(1);
            end
            default: ;
          endcase
        end
      end else if (in_normal) begin
        imr_d = wr_data;
      end else begin
        case (st_q)
          ST_BASE: begin
            vbase_d = wr_data[DATA_W-1:IDX_W];
            if (!single_q)   st_d = ST_CASC;
            else if (need4_q) st_d = ST_FOURTH;
            else              st_d = ST_NORMAL;
          end
          ST_CASC:   st_d = need4_q ? ST_FOURTH : ST_NORMAL;
          ST_FOURTH: begin
            fnm_d  = wr_data[4];
            aeoi_d = wr_data[1];
            st_d   = ST_NORMAL;
          end
          default: st_d = ST_NORMAL;
        endcase
      end
    end else if (rd_en) begin
      if (poll_q) begin
        poll_d = 1'b0;
        if (fire) begin
          rd_d             = DATA_W'(pend_line);
          irr_d[pend_line] = 1'b0;
          isr_d[pend_line] = 1'b0;
        end else begin
          rd_d = DATA_W'(LINES - 1);
        end
      end else if (addr) begin
        rd_d = imr_q;
      end else begin
        rd_d = rdsel_q ? isr_q : irr_q;
      end
    end else if (ack) begin
      if (fire) begin
        vec_d            = {vbase_q, pend_line};
        irr_d[pend_line] = 1'b0;
        if (aeoi_q) begin
          if (rot_q) base_d = pend_line + IDX_W'(1);
        end else begin
          isr_d[pend_line] = 1'b1;
        end
      end else begin
        vec_d = {vbase_q, IDX_W'(LINES - 1)};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q    <= '0;
      imr_q    <= '0;
      isr_q    <= '0;
      base_q   <= '0;
      vbase_q  <= '0;
      rdsel_q  <= 1'b0;
      poll_q   <= 1'b0;
      smm_q    <= 1'b0;
      aeoi_q   <= 1'b0;
      rot_q    <= 1'b0;
      fnm_q    <= 1'b0;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      st_q     <= ST_NORMAL;
      rd_q     <= '0;
      vec_q    <= '0;
      int_q    <= 1'b0;
    end else begin
      irr_q    <= irr_d;
      imr_q    <= imr_d;
      isr_q    <= isr_d;
      base_q   <= base_d;
      vbase_q  <= vbase_d;
      rdsel_q  <= rdsel_d;
      poll_q   <= poll_d;
      smm_q    <= smm_d;
      aeoi_q   <= aeoi_d;
      rot_q    <= rot_d;
      fnm_q    <= fnm_d;
      need4_q  <= need4_d;
      single_q <= single_d;
      st_q     <= st_d;
      rd_q     <= rd_d;
      vec_q    <= vec_d;
      int_q    <= int_d;
    end
  end

  assign rd_data = rd_q;
  assign vector  = vec_q;
  assign int_out = int_q;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              ack,
  input logic              addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] vector,
  input logic              int_out,
  input logic [LINES-1:0]  imr_q,
  input logic [LINES-1:0]  isr_q,
  input logic [VB_W-1:0]   vbase_q,
  input logic              poll_q,
  input logic              aeoi_q,
  input logic              in_normal
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !int_out);

  assert_init_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wr_data[4]) |=> !int_out);

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && in_normal) |=> (imr_q == $past(wr_data)));

  assert_vector_base_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_en && !rd_en) |=> (vector[DATA_W-1:IDX_W] == $past(vbase_q)));

  assert_auto_eoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (ack && !wr_en && !rd_en && aeoi_q) |=> (isr_q == $past(isr_q)));

  assert_poll_self_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && poll_q) |=> !poll_q);

  assert_read_loses_R13: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en) |=> $stable(rd_data));
endmodule

bind irqc_top irqc_checker u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .ack(ack), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .vector(vector), .int_out(int_out),
  .imr_q(imr_q), .isr_q(isr_q), .vbase_q(vbase_q), .poll_q(poll_q),
  .aeoi_q(aeoi_q), .in_normal(in_normal)
);

// File: tb/tb_irqc_top.sv
module tb_irqc_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_in;
  logic       wr_en, rd_en, addr, ack;
  logic [7:0] wr_data;
  logic [7:0] rd_data, vector;
  logic       int_out;

  int n_vec = 0;
  int n_bad = 0;

  // reference state
  logic [7:0] m_irr, m_imr, m_isr, m_last, m_rd, m_vec;
  logic [2:0] m_base;
  logic [4:0] m_vbase;
  logic       m_rdsel, m_poll, m_smm, m_aeoi, m_rot, m_fnm, m_need4, m_single;
  int         m_st;

  always #10 clk = ~clk;

  irqc_top dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .ack(ack),
    .vector(vector), .int_out(int_out)
  );

  function automatic int rank_of(logic [7:0] v, logic [2:0] b);
    for (int k = 0; k < 8; k++) if (v[3'(b + 3'(k))]) return k;
    return 8;
  endfunction

  function automatic logic m_fire();
    logic [7:0] cv;
    cv = m_isr;
    if (m_smm) cv = cv & ~m_imr;
    if (m_fnm) cv[2] = 1'b0;
    return rank_of(m_irr & ~m_imr, m_base) < rank_of(cv, m_base);
  endfunction

  function automatic logic [2:0] m_pline();
    return 3'(m_base + 3'(rank_of(m_irr & ~m_imr, m_base)));
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_irr = 0; m_imr = 0; m_isr = 0; m_last = 0; m_rd = 0; m_vec = 0;
    m_base = 0; m_vbase = 0; m_rdsel = 0; m_poll = 0; m_smm = 0;
    m_aeoi = 0; m_rot = 0; m_fnm = 0; m_need4 = 0; m_single = 0; m_st = 0;
  endtask

  task automatic m_write(logic a, logic [7:0] d);
    int r;
    logic [2:0] l;
    if (!a) begin
      if (d[4]) begin
        m_irr = 0; m_imr = 0; m_isr = 0; m_base = 0; m_vbase = 0;
        m_rdsel = 0; m_poll = 0; m_smm = 0; m_aeoi = 0; m_rot = 0; m_fnm = 0;
        m_need4 = d[0]; m_single = d[1]; m_st = 1;
      end else if (d[3]) begin
        if (d[2]) m_poll = 1;
        if (d[1]) m_rdsel = d[0];
        if (d[6]) m_smm = d[5];
      end else begin
        case (d[7:5])
          3'd0: m_rot = 0;
          3'd4: m_rot = 1;
          3'd1, 3'd5: begin
            r = rank_of(m_isr, m_base);
            if (r < 8) begin
              l = 3'(m_base + 3'(r));
              m_isr[l] = 0;
              if (d[7]) m_base = l + 3'd1;
            end
          end
          3'd3: m_isr[d[2:0]] = 0;
          3'd6: m_base = d[2:0] + 3'd1;
          3'd7: begin m_isr[d[2:0]] = 0; m_base = d[2:0] + 3'd1; end
          default: ;
        endcase
      end
    end else begin
      case (m_st)
        0: m_imr = d;
        1: begin m_vbase = d[7:3]; m_st = !m_single ? 2 : (m_need4 ? 3 : 0); end
        2: m_st = m_need4 ? 3 : 0;
        default: begin m_fnm = d[4]; m_aeoi = d[1]; m_st = 0; end
      endcase
    end
  endtask

  task automatic m_read(logic a);
    logic [2:0] l;
    if (m_poll) begin
      m_poll = 0;
      if (m_fire()) begin
        l = m_pline(); m_rd = {5'd0, l}; m_irr[l] = 0; m_isr[l] = 0;
      end else m_rd = 8'h07;
    end else m_rd = a ? m_imr : (m_rdsel ? m_isr : m_irr);
  endtask

  task automatic m_ack();
    logic [2:0] l;
    if (m_fire()) begin
      l = m_pline();
      m_vec = {m_vbase, l};
      m_irr[l] = 0;
      if (m_aeoi) begin
        if (m_rot) m_base = l + 3'd1;
      end else m_isr[l] = 1;
    end else m_vec = {m_vbase, 3'd7};
  endtask

  // One transaction: strobes for one edge, then one idle edge before the
  // output level is compared.
  task automatic op(logic w, logic r, logic k, logic a, logic [7:0] d, string req);
    @(negedge clk);
    wr_en = w; rd_en = r; ack = k; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0; ack = 0;
    if (w) m_write(a, d);
    else if (r) m_read(a);
    else if (k) m_ack();
    if (r) chk({req, "/R6 rd_data"}, rd_data, m_rd);
    if (k) chk({req, "/R9 vector"}, vector, m_vec);
    @(negedge clk);
    chk({req, "/R3 int_out"}, {7'd0, int_out}, {7'd0, m_fire()});
  endtask

  task automatic set_irq(logic [7:0] v, string req);
    @(negedge clk);
    irq_in = v;
    m_irr = m_irr | (v & ~m_last);
    m_last = v;
    @(negedge clk);
    @(negedge clk);
    chk({req, " int_out"}, {7'd0, int_out}, {7'd0, m_fire()});
  endtask

  task automatic wr(logic a, logic [7:0] d, string req); op(1, 0, 0, a, d, req); endtask
  task automatic rd(logic a, string req);                op(0, 1, 0, a, 8'h00, req); endtask
  task automatic ak(string req);                         op(0, 0, 1, 0, 8'h00, req); endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed;
    int sel;
    logic [7:0] rv;
    seed = $urandom(32'h5EED_0042);
    rst = 1; irq_in = 0; wr_en = 0; rd_en = 0; ack = 0; addr = 0; wr_data = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 int_out", {7'd0, int_out}, 8'h00);
    chk("R1 vector", vector, 8'h00);
    rd(0, "R1 irr");
    rd(1, "R1 imr");

    // R5: full sequence with cascade and fourth word
    wr(0, 8'h11, "R4 start");
    wr(1, 8'h20, "R5 base");
    wr(1, 8'h55, "R5 cascade");
    wr(1, 8'h00, "R5 fourth");
    rd(1, "R5 mask untouched");
    chk("R5 mask", m_imr, 8'h00);

    // R2, R3, R9, R8
    set_irq(8'h08, "R2 edge line3");
    chk("R2 int high", {7'd0, int_out}, 8'h01);
    ak("R9 ack line3");
    chk("R9 vector", vector, 8'h23);
    set_irq(8'h0A, "R3 line1 preempts");
    chk("R3 preempt", {7'd0, int_out}, 8'h01);
    ak("R9 ack line1");
    chk("R9 vector line1", vector, 8'h21);
    wr(0, 8'h0B, "R7 select isr");
    rd(0, "R7 isr read");
    chk("R7 isr", rd_data, 8'h0A);
    wr(0, 8'h20, "R8 nonspecific eoi");
    rd(0, "R8 isr after eoi");
    chk("R8 isr", rd_data, 8'h08);
    ak("R11 spurious");
    chk("R11 vector", vector, 8'h27);
    set_irq(8'h00, "R2 drop");
    set_irq(8'h0A, "R2 re-raise");
    wr(0, 8'h0C, "R12 poll");
    rd(0, "R12 poll read");
    chk("R12 line", rd_data, 8'h01);
    wr(0, 8'h0C, "R12 poll again");
    rd(0, "R12 poll read 2");
    wr(0, 8'h63, "R8 specific eoi 3");
    wr(0, 8'hC4, "R8 set base 5");
    wr(0, 8'h40, "R8 no-op code 2");

    // R13 overlap: write beats read
    op(1, 1, 0, 1, 8'hF0, "R13 write beats read");
    rd(1, "R13 mask loaded");
    chk("R13 mask", rd_data, 8'hF0);
    op(0, 1, 1, 1, 8'h00, "R13 read beats ack");
    wr(1, 8'h00, "R6 unmask");

    // R10: single, auto end-of-interrupt with rotation
    wr(0, 8'h13, "R4 start single");
    wr(1, 8'h40, "R5 base single");
    wr(1, 8'h02, "R5 fourth aeoi");
    wr(0, 8'h80, "R8 rotate on");
    set_irq(8'h00, "R10 clear lines");
    set_irq(8'h20, "R10 line5");
    ak("R10 ack line5");
    chk("R10 vector", vector, 8'h45);
    wr(0, 8'h0B, "R10 select isr");
    rd(0, "R10 isr empty");
    chk("R10 isr", rd_data, 8'h00);
    chk("R10 base", {5'd0, m_base}, 8'h06);

    // R4: init while output is high
    set_irq(8'h21, "R4 raise line0");
    wr(0, 8'h12, "R4 init drops");
    chk("R4 int low", {7'd0, int_out}, 8'h00);
    wr(1, 8'h00, "R5 base only");

    // special mask and fully nested variants
    wr(0, 8'h68, "R7 special mask on");
    set_irq(8'h00, "R3 lines low");

    for (int i = 0; i < 1500; i++) begin
      sel = $urandom_range(0, 9);
      rv = 8'($urandom);
      case (sel)
        0, 1: set_irq(rv, "R2 random lines");
        2:    wr(1, rv, "R6 random addr1");
        3, 4: ak("R9 random ack");
        5:    wr(0, {rv[7:5], 2'b00, rv[2:0]}, "R8 random cmd");
        6:    wr(0, {rv[7:5], 2'b01, rv[2:0]}, "R7 random ctrl");
        7, 8: rd(rv[0], "R6 random read");
        default: if (rv[7:5] == 3'd0) wr(0, {3'd0, 2'b10, rv[2:0]}, "R4 random init");
                 else rd(0, "R12 random read");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule